// File: doc/BRIEF.md
# Sensor register access controller over I2C

This block runs one complete register access on a two-wire I2C bus: it either writes one 8-bit value into a register of a slave device, or reads one 8-bit value back. A host presents a request with a read/write flag, an 8-bit device address (bit 0 is ignored and replaced by the direction bit), a register index and, for writes, a data byte. The block then handles the whole bus exchange. It returns a one-cycle done pulse, an error flag that reports any missing acknowledge, and the read byte.

The bus exchange is made of fixed-length steps. The length of one step is a parameter given in clock cycles; the default is 500 cycles, which is 4 us at 125 MHz. Every START, STOP, data bit, acknowledge check and the master NACK is built from two or three of these steps. A read is sent as two separate transactions. The first sets the register pointer and ends with a STOP. The second starts with a fresh START and fetches the byte. SDA is driven as a push-pull level while the block is busy, and a released line is driven high.

Top module: `i2c_reg_master`

## Requirements
- R1: After reset and whenever no transaction is in progress, busy_o and sda_oe_o are low, and scl_o and sda_o are high.
- R2: A request seen while busy_o is low starts a transaction, and busy_o is high in the next cycle. sda_oe_o is high for as long as busy_o is high. A request seen while busy_o is high is ignored: it causes no further bus traffic and no further done pulse.
- R3: A write produces exactly one START and one STOP. Between them it sends the address byte {dev_addr_i[7:1],0}, then the register index, then the data byte, each MSB first and each followed by an acknowledge check.
- R4: A read produces two START/STOP pairs. The first pair carries {dev_addr_i[7:1],0} and the register index. The second carries {dev_addr_i[7:1],1}, then receives 8 bits MSB first into rdata_o, then drives a NACK (SDA high during one SCL pulse) before the STOP.
- R5: A START lowers SDA while SCL is high and then lowers SCL. A STOP runs three steps: SDA low with SCL low, then SCL high, then SDA high.
- R6: Each sent bit takes three steps with SDA held at the bit value and SCL low, high, low. SDA changes while SCL is high only as part of a START or STOP.
- R7: Every step lasts STEP_CYCLES clock cycles, and the bus lines change only at step boundaries. Each SCL pulse of a bit, acknowledge or NACK is high for exactly one step. The SCL high time that spans a read's STOP and its next START is three steps.
- R8: An acknowledge is SDA low, sampled at the end of the SCL-high step of the acknowledge clock. If any acknowledge is sampled high, the transaction still runs to its final STOP, and err_o is 1 when done_o pulses. Otherwise err_o is 0. A read whose slave does not drive SDA returns 8'hFF.
- R9: done_o is high for one cycle, in the same cycle that busy_o falls. rdata_o (cleared to 0 when a request is accepted) and err_o hold their values until the next request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Start a transaction (taken only while idle) |
| cmd_read_i | input | 1 | 1 = register read, 0 = register write |
| dev_addr_i | input | 8 | Device address byte; bit 0 replaced by direction |
| reg_addr_i | input | 8 | Register index |
| wdata_i | input | 8 | Write data |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | One-cycle end-of-transaction pulse |
| err_o | output | 1 | At least one acknowledge was missing |
| rdata_o | output | 8 | Byte received by a read |
| scl_o | output | 1 | Clock line level |
| sda_o | output | 1 | Data line drive level (high = released) |
| sda_oe_o | output | 1 | Data line driver enable |
| sda_i | input | 1 | Sampled data line |

## Verification
The bench builds the block with STEP_CYCLES = 4 and SYNC_STAGES = 2. The short step makes a full two-transaction read take a few hundred cycles, so many transactions fit in one run. It also lets SCL pulse widths be measured exactly in whole steps. Keeping two synchronizer stages inside a four-cycle step shows that the acknowledge and data samples still land inside the SCL-high window. A behavioural slave on the bus covers three cases: acknowledged exchanges, a wrong device address that leaves every acknowledge missing, and a refused data byte.

// File: rtl/i2c_reg_pkg.sv
package i2c_reg_pkg;

  localparam int BYTE_W    = 8;
  localparam int BIT_IDX_W = $clog2(BYTE_W);
  localparam int SEG_IDX_W = 4;
  localparam int STEP_W    = 2;

  typedef enum logic [2:0] {
    SEG_START,
    SEG_TX,
    SEG_ACK,
    SEG_RX,
    SEG_NACK,
    SEG_STOP
  } seg_kind_e;

  typedef enum logic [1:0] {
    TXB_ADDR_WR,
    TXB_REG,
    TXB_DATA,
    TXB_ADDR_RD
  } txb_sel_e;

  typedef struct packed {
    seg_kind_e kind;
    txb_sel_e  sel;
    logic      last;
  } seg_t;

  // segment program for one request
  function automatic seg_t seg_at(input logic rd, input logic [SEG_IDX_W-1:0] idx);
    seg_t s;
    s = seg_t'{kind: SEG_STOP, sel: TXB_ADDR_WR, last: 1'b1};
    case (idx)
      4'd0: s = seg_t'{kind: SEG_START, sel: TXB_ADDR_WR, last: 1'b0};
      4'd1: s = seg_t'{kind: SEG_TX,    sel: TXB_ADDR_WR, last: 1'b0};
      4'd2: s = seg_t'{kind: SEG_ACK,   sel: TXB_ADDR_WR, last: 1'b0};
      4'd3: s = seg_t'{kind: SEG_TX,    sel: TXB_REG,     last: 1'b0};
      4'd4: s = seg_t'{kind: SEG_ACK,   sel: TXB_REG,     last: 1'b0};
      default: begin
        if (rd) begin
          case (idx)
            4'd5:  s = seg_t'{kind: SEG_STOP,  sel: TXB_REG,     last: 1'b0};
            4'd6:  s = seg_t'{kind: SEG_START, sel: TXB_ADDR_RD, last: 1'b0};
            4'd7:  s = seg_t'{kind: SEG_TX,    sel: TXB_ADDR_RD, last: 1'b0};
            4'd8:  s = seg_t'{kind: SEG_ACK,   sel: TXB_ADDR_RD, last: 1'b0};
            4'd9:  s = seg_t'{kind: SEG_RX,    sel: TXB_ADDR_RD, last: 1'b0};
            4'd10: s = seg_t'{kind: SEG_NACK,  sel: TXB_ADDR_RD, last: 1'b0};
            default: s = seg_t'{kind: SEG_STOP, sel: TXB_ADDR_RD, last: 1'b1};
          endcase
        end else begin
          case (idx)
            4'd5:  s = seg_t'{kind: SEG_TX,   sel: TXB_DATA, last: 1'b0};
            4'd6:  s = seg_t'{kind: SEG_ACK,  sel: TXB_DATA, last: 1'b0};
            default: s = seg_t'{kind: SEG_STOP, sel: TXB_DATA, last: 1'b1};
          endcase
        end
      end
    endcase
    return s;
  endfunction

  function automatic logic [STEP_W-1:0] step_last(input seg_kind_e k);
    case (k)
      SEG_START, SEG_RX, SEG_NACK: return 2'd1;
      default:                     return 2'd2;
    endcase
  endfunction

endpackage

// File: rtl/i2c_step_timer.sv
module i2c_step_timer #(
  parameter int STEP_CYCLES = 500
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);
  localparam int CNT_W = (STEP_CYCLES > 1) ? $clog2(STEP_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STEP_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (!run_i)           cnt_q <= '0;
    else if (cnt_q == CNT_LAST) cnt_q <= '0;
    else                       cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = run_i && (cnt_q == CNT_LAST);
endmodule

// File: rtl/i2c_sda_sync.sv
module i2c_sda_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sda_i,
  output logic sda_o
);
  logic [STAGES:0] chain;
  assign chain[0] = sda_i;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain[g+1] <= 1'b1;
      else         chain[g+1] <= chain[g];
    end
  end

  assign sda_o = chain[STAGES];
endmodule

// File: rtl/i2c_seq.sv
module i2c_seq
  import i2c_reg_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic                 is_rd_i,
  input  logic                 tick_i,
  output logic                 busy_o,
  output logic                 done_o,
  output seg_kind_e            kind_o,
  output txb_sel_e             sel_o,
  output logic [STEP_W-1:0]    step_o,
  output logic [BIT_IDX_W-1:0] bit_o,
  output logic                 sample_ack_o,
  output logic                 sample_rx_o
);
  localparam logic [BIT_IDX_W-1:0] BIT_LAST = BIT_IDX_W'(BYTE_W - 1);

  logic                 busy_q, done_q;
  logic [SEG_IDX_W-1:0] seg_q;
  logic [STEP_W-1:0]    step_q;
  logic [BIT_IDX_W-1:0] bit_q;
  seg_t                 cur;
  logic                 byte_seg, step_end, seg_end;

  assign cur      = seg_at(is_rd_i, seg_q);
  assign byte_seg = (cur.kind == SEG_TX) || (cur.kind == SEG_RX);
  assign step_end = tick_i && (step_q == step_last(cur.kind));
  assign seg_end  = step_end && (!byte_seg || (bit_q == BIT_LAST));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      seg_q  <= '0;
      step_q <= '0;
      bit_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start_i) begin
          busy_q <= 1'b1;
          seg_q  <= '0;
          step_q <= '0;
          bit_q  <= '0;
        end
      end else if (tick_i) begin
        if (!step_end) begin
          step_q <= step_q + 1'b1;
        end else begin
          step_q <= '0;
          if (!seg_end) begin
            bit_q <= bit_q + 1'b1;
          end else begin
            bit_q <= '0;
            if (cur.last) begin
              busy_q <= 1'b0;
              done_q <= 1'b1;
            end else begin
              seg_q <= seg_q + 1'b1;
            end
          end
        end
      end
    end
  end

  assign busy_o       = busy_q;
  assign done_o       = done_q;
  assign kind_o       = cur.kind;
  assign sel_o        = cur.sel;
  assign step_o       = step_q;
  assign bit_o        = bit_q;
  // sample at the last cycle of the SCL-high step
  assign sample_ack_o = busy_q && tick_i && (cur.kind == SEG_ACK) && (step_q == 2'd1);
  assign sample_rx_o  = busy_q && tick_i && (cur.kind == SEG_RX)  && (step_q == 2'd0);
endmodule

// File: rtl/i2c_byte_path.sv
module i2c_byte_path
  import i2c_reg_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 load_i,
  input  logic [BYTE_W-1:0]    dev_addr_i,
  input  logic [BYTE_W-1:0]    reg_addr_i,
  input  logic [BYTE_W-1:0]    wdata_i,
  input  txb_sel_e             sel_i,
  input  logic [BIT_IDX_W-1:0] bit_i,
  input  logic                 sample_ack_i,
  input  logic                 sample_rx_i,
  input  logic                 sda_i,
  output logic                 tx_bit_o,
  output logic [BYTE_W-1:0]    rdata_o,
  output logic                 err_o
);
  logic [BYTE_W-2:0] dev_q;
  logic [BYTE_W-1:0] reg_q, wdata_q, rx_q, tx_byte;
  logic              err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dev_q   <= '0;
      reg_q   <= '0;
      wdata_q <= '0;
    end else if (load_i) begin
      dev_q   <= dev_addr_i[BYTE_W-1:1];
      reg_q   <= reg_addr_i;
      wdata_q <= wdata_i;
    end
  end

  always_comb begin
    case (sel_i)
      TXB_ADDR_WR: tx_byte = {dev_q, 1'b0};
      TXB_ADDR_RD: tx_byte = {dev_q, 1'b1};
      TXB_REG:     tx_byte = reg_q;
      default:     tx_byte = wdata_q;
    endcase
  end

  // MSB first
  assign tx_bit_o = tx_byte[BIT_IDX_W'(BYTE_W - 1) - bit_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_q  <= '0;
      err_q <= 1'b0;
    end else if (load_i) begin
      rx_q  <= '0;
      err_q <= 1'b0;
    end else begin
      if (sample_rx_i)          rx_q  <= {rx_q[BYTE_W-2:0], sda_i};
      if (sample_ack_i && sda_i) err_q <= 1'b1;
    end
  end

  assign rdata_o = rx_q;
  assign err_o   = err_q;
endmodule

// File: rtl/i2c_reg_master.sv
module i2c_reg_master
  import i2c_reg_pkg::*;
#(
  parameter int STEP_CYCLES = 500,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       req_i,
  input  logic       cmd_read_i,
  input  logic [7:0] dev_addr_i,
  input  logic [7:0] reg_addr_i,
  input  logic [7:0] wdata_i,
  output logic       busy_o,
  output logic       done_o,
  output logic       err_o,
  output logic [7:0] rdata_o,
  output logic       scl_o,
  output logic       sda_o,
  output logic       sda_oe_o,
  input  logic       sda_i
);
  logic                 busy_w, done_w, tick_w, accept_w, is_rd_q;
  logic                 tx_bit_w, sample_ack_w, sample_rx_w, sda_s_w;
  seg_kind_e            kind_w;
  txb_sel_e             sel_w;
  logic [STEP_W-1:0]    step_w;
  logic [BIT_IDX_W-1:0] bit_w;
  logic                 scl_n, sda_n, scl_q, sda_q;

  assign accept_w = req_i && !busy_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       is_rd_q <= 1'b0;
    else if (accept_w) is_rd_q <= cmd_read_i;
  end

  i2c_step_timer #(.STEP_CYCLES(STEP_CYCLES)) u_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (busy_w),
    .tick_o(tick_w)
  );

  i2c_sda_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .sda_i (sda_i),
    .sda_o (sda_s_w)
  );

  i2c_seq u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (accept_w),
    .is_rd_i     (is_rd_q),
    .tick_i      (tick_w),
    .busy_o      (busy_w),
    .done_o      (done_w),
    .kind_o      (kind_w),
    .sel_o       (sel_w),
    .step_o      (step_w),
    .bit_o       (bit_w),
    .sample_ack_o(sample_ack_w),
    .sample_rx_o (sample_rx_w)
  );

  i2c_byte_path u_path (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (accept_w),
    .dev_addr_i  (dev_addr_i),
    .reg_addr_i  (reg_addr_i),
    .wdata_i     (wdata_i),
    .sel_i       (sel_w),
    .bit_i       (bit_w),
    .sample_ack_i(sample_ack_w),
    .sample_rx_i (sample_rx_w),
    .sda_i       (sda_s_w),
    .tx_bit_o    (tx_bit_w),
    .rdata_o     (rdata_o),
    .err_o       (err_o)
  );

  // step -> line levels
  always_comb begin
    scl_n = 1'b1;
    sda_n = 1'b1;
    if (busy_w) begin
      case (kind_w)
        SEG_START: begin scl_n = (step_w == 2'd0); sda_n = 1'b0;             end
        SEG_TX:    begin scl_n = (step_w == 2'd1); sda_n = tx_bit_w;         end
        SEG_ACK:   begin scl_n = (step_w == 2'd1); sda_n = 1'b1;             end
        SEG_RX:    begin scl_n = (step_w == 2'd0); sda_n = 1'b1;             end
        SEG_NACK:  begin scl_n = (step_w == 2'd0); sda_n = 1'b1;             end
        default:   begin scl_n = (step_w != 2'd0); sda_n = (step_w == 2'd2); end
      endcase
    end
  end

  // registered lines: glitch-free pins
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_n;
      sda_q <= sda_n;
    end
  end

  assign scl_o    = scl_q;
  assign sda_o    = sda_q;
  assign sda_oe_o = busy_w;
  assign busy_o   = busy_w;
  assign done_o   = done_w;
endmodule

// File: rtl/i2c_reg_master_chk.sv
module i2c_reg_master_chk
  import i2c_reg_pkg::*;
(
  input logic      clk_i,
  input logic      rst_ni,
  input logic      req_i,
  input logic      busy_i,
  input logic      done_i,
  input logic      scl_i,
  input logic      line_sda_i,
  input logic      tick_i,
  input seg_kind_e kind_i
);
  p_idle_lines_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> (scl_i && line_sda_i));

  p_accept_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !busy_i) |=> busy_i);

  p_sda_scl_high_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && scl_i && $past(scl_i) && !$stable(line_sda_i)) |->
      ($past(kind_i) == SEG_START || $past(kind_i) == SEG_STOP));

  p_step_edge_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && $past(busy_i, 2) && (!$stable(scl_i) || !$stable(line_sda_i))) |->
      $past(tick_i, 2));

  p_fall_done_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_i) |-> done_i);

  p_done_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> !done_i);
endmodule

bind i2c_reg_master i2c_reg_master_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .req_i     (req_i),
  .busy_i    (busy_o),
  .done_i    (done_o),
  .scl_i     (scl_o),
  .line_sda_i(sda_o),
  .tick_i    (tick_w),
  .kind_i    (kind_w)
);

// File: tb/i2c_reg_master_bench.sv
module i2c_reg_master_bench;
  localparam int STEP = 4;
  localparam int SYNC = 2;
  localparam logic [7:0] SLV = 8'h42;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;  // 8 ns period

  logic req = 1'b0, rd = 1'b0;
  logic [7:0] dev = '0, ra = '0, wd = '0;
  logic busy, done, err, scl, sda, oe;
  logic [7:0] rdata;
  logic slv_low = 1'b0;
  wire  sda_line = (oe ? sda : 1'b1) & ~slv_low;

  i2c_reg_master #(.STEP_CYCLES(STEP), .SYNC_STAGES(SYNC)) u_i2c_reg_master (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .cmd_read_i(rd),
    .dev_addr_i(dev), .reg_addr_i(ra), .wdata_i(wd),
    .busy_o(busy), .done_o(done), .err_o(err), .rdata_o(rdata),
    .scl_o(scl), .sda_o(sda), .sda_oe_o(oe), .sda_i(sda_line)
  );

  int n_cmp = 0, n_bad = 0;

  task automatic check(input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", rq, what, act, exp);
    end
  endtask

  // ---------------- behavioural slave ----------------
  logic [7:0] mem [256];
  logic [7:0] sh, txb, ptr;
  int  rbit = 0, tbit = 0, bytec = 0;
  bit  ack_ph = 0, tx_ph = 0, rd_mode = 0, addr_ok = 0, do_ack = 0;
  bit  nak_data = 0;
  logic m_nack = 1'b0;
  int  n_start = 0, n_stop = 0;

  always @(negedge sda_line) if (scl) begin
    n_start++; rbit = 0; bytec = 0; ack_ph = 0; tx_ph = 0;
  end
  always @(posedge sda_line) if (scl) n_stop++;

  always @(posedge scl) begin
    if (tx_ph) begin
      if (tbit == 8) m_nack = sda_line;
    end else if (!ack_ph) begin
      sh = {sh[6:0], sda_line};
      rbit++;
    end
  end

  always @(negedge scl) begin
    if (ack_ph) begin
      ack_ph = 0; slv_low = 1'b0;
      if (rd_mode && addr_ok && bytec == 1) begin
        tx_ph = 1; tbit = 0; txb = mem[ptr]; slv_low = ~txb[7];
      end
    end else if (tx_ph) begin
      tbit++;
      if (tbit < 8) slv_low = ~txb[7-tbit];
      else          slv_low = 1'b0;
      if (tbit == 9) tx_ph = 0;
    end else if (rbit == 8) begin
      rbit = 0; do_ack = 0;
      if (bytec == 0) begin
        rd_mode = sh[0]; addr_ok = (sh[7:1] == SLV[7:1]); do_ack = addr_ok;
      end else if (addr_ok && !rd_mode) begin
        if (bytec == 1) begin ptr = sh; do_ack = 1; end
        else if (!nak_data) begin mem[ptr] = sh; do_ack = 1; end
      end
      bytec++; ack_ph = 1; slv_low = do_ack;
    end
  end

  // ---------------- SCL pulse width monitor ----------------
  time t_rise = 0;
  int  n_bitw = 0, n_gap = 0;
  always @(posedge scl) t_rise = $time;
  always @(negedge scl) begin
    if (($time - t_rise) == 8 * STEP)          n_bitw++;
    else if (($time - t_rise) == 3 * 8 * STEP) n_gap++;
  end

  // ---------------- scoreboard ----------------
  typedef struct { logic [7:0] rd; logic er; string rq; } exp_t;
  exp_t exp_q[$];

  always @(negedge clk) begin
    exp_t e;
    if (rst_n && done) begin
      if (exp_q.size() == 0) check("R9", "unexpected done", 1, 0);
      else begin
        e = exp_q.pop_front();
        check(e.rq, "rdata", rdata, e.rd);
        check(e.rq, "err", err, e.er);
      end
    end
  end

  task automatic run_txn(input bit is_rd, input logic [7:0] a, input logic [7:0] r,
                         input logic [7:0] d, input logic [7:0] exp_rd, input bit exp_err,
                         input string rq, input bit poke_busy);
    int s0, p0, hi;
    exp_t e;
    @(negedge clk);
    while (busy) @(negedge clk);
    s0 = n_start; p0 = n_stop; n_bitw = 0; n_gap = 0; m_nack = 1'b0;
    e.rd = exp_rd; e.er = exp_err; e.rq = rq;
    exp_q.push_back(e);
    req = 1'b1; rd = is_rd; dev = a; ra = r; wd = d;
    @(negedge clk);
    req = 1'b0;
    check("R2", "busy after accept", busy, 1);
    check("R2", "oe while busy", oe, 1);
    if (poke_busy) begin
      repeat (20) @(negedge clk);
      req = 1'b1; rd = 1'b1; ra = 8'h77; wd = 8'hEE;
      @(negedge clk);
      req = 1'b0;
    end
    while (!done) @(negedge clk);
    hi = 0;
    @(negedge clk);
    check("R9", "done one cycle", done, 0);
    check("R1", "oe low when idle", oe, 0);
    check("R1", "scl/sda idle high", {scl, sda}, 2'b11);
    check(is_rd ? "R4" : "R3", "start count", n_start - s0, is_rd ? 2 : 1);
    check("R5", "stop count", n_stop - p0, is_rd ? 2 : 1);
    check("R7", "one-step scl pulses", n_bitw, is_rd ? 36 : 27);
    check("R7", "three-step stop-start gap", n_gap, is_rd ? 1 : 0);
    if (is_rd && !exp_err) check("R4", "master nack seen", m_nack, 1);
    if (poke_busy) begin
      repeat (40) @(negedge clk);
      check("R2", "busy request ignored: busy", busy, 0);
      check("R2", "busy request ignored: starts", n_start - s0, 1);
    end
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'h5A;
    repeat (3) @(negedge clk);
    check("R1", "busy in reset", busy, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1", "reset busy", busy, 0);
    check("R1", "reset oe", oe, 0);
    check("R1", "reset lines", {scl, sda}, 2'b11);
    check("R9", "reset done", done, 0);

    run_txn(0, SLV, 8'h10, 8'hA5, 8'h00, 0, "R3", 0);
    check("R3", "slave reg 0x10", mem[8'h10], 8'hA5);
    run_txn(0, SLV | 8'h01, 8'h11, 8'h3C, 8'h00, 0, "R3", 0);
    check("R3", "slave reg 0x11 (addr bit0 ignored)", mem[8'h11], 8'h3C);
    run_txn(1, SLV, 8'h10, 8'h00, 8'hA5, 0, "R4", 0);
    run_txn(1, SLV, 8'h80, 8'h00, 8'h80 ^ 8'h5A, 0, "R4", 0);
    run_txn(1, SLV, 8'h11, 8'h00, 8'h3C, 0, "R4", 0);

    run_txn(0, 8'h50, 8'h20, 8'h99, 8'h00, 1, "R8", 0);
    check("R8", "no write on address nack", mem[8'h20], 8'h20 ^ 8'h5A);
    run_txn(1, 8'h50, 8'h20, 8'h00, 8'hFF, 1, "R8", 0);
    nak_data = 1;
    run_txn(0, SLV, 8'h21, 8'h66, 8'h00, 1, "R8", 0);
    nak_data = 0;
    check("R8", "refused data not stored", mem[8'h21], 8'h21 ^ 8'h5A);

    run_txn(0, SLV, 8'h30, 8'hC3, 8'h00, 0, "R2", 1);
    check("R2", "first request data kept", mem[8'h30], 8'hC3);
    check("R2", "busy request did not write 0x77", mem[8'h77], 8'h77 ^ 8'h5A);

    run_txn(1, SLV, 8'h30, 8'h00, 8'hC3, 0, "R4", 0);
    repeat (30) @(negedge clk);
    check("R9", "rdata held", rdata, 8'hC3);
    check("R9", "err held", err, 0);
    check("R9", "no extra done", done, 0);
    check("R9", "scoreboard drained", exp_q.size(), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule